// File: doc/BRIEF.md
# Memory-Mapped 64-bit Signature CRC Engine

This block computes a 64-bit CRC signature over data that a bus master writes into it one word at a time. It sits on a simple register bus with a request strobe, write enable, byte strobes, write data, read data and a ready signal. A master first loads a seed into the signature while the engine is in capture mode. It then switches to compression mode and writes each data word to the signature location. Each such write folds the word into the running signature in a single clock. The master then reads the final signature, or the result copy, and compares it with a value computed elsewhere.

The signature is split into a low and a high 32-bit word, and the low word sits at the lower address. A write of fewer than 64 bits is widened to a 64-bit word before it is folded. Bytes that were not strobed become zero, and so does the half that was not addressed. The polynomial is x^64 + x^4 + x^3 + x + 1. One fold is the exact equivalent of shifting all 64 data bits serially into the signature, MSB first.

Top module: `sig_crc_engine`

## Requirements
- R1: After `rst_n` is released, every register reads zero: the soft-reset bit, the mode, the status bit, the signature and the result copies.
- R2: `bus_ready` is always 1. A write takes effect at the clock edge where `bus_sel` and `bus_we` are high. Read data is a combinational function of `bus_addr` and the current register state.
- R3: Bit 0 at offset 0x00 is a soft reset, written through strobe lane 0. While the bit is 1, the signature is held at zero, writes to it have no effect, and no fold takes place.
- R4: Bits [1:0] at offset 0x10 select the mode. Value 3 is compression mode. Values 0, 1 and 2 all act as capture mode. The mode changes only through a write to 0x10.
- R5: In capture mode, a write to 0x60 (signature bits 31:0) or to 0x64 (bits 63:32) stores each strobed byte unchanged. Bytes that are not strobed and the other half keep their values. Status and the result copies do not change.
- R6: In compression mode, a write to 0x60 replaces the signature with fold(S, {32'h0, W}). The fold shifts the 64 bits of data into S serially, MSB first. At each bit, fb = S[63] ^ d, then S = (S << 1) ^ (fb ? 64'h1B : 0). For example, seed 0 with the data word 0x01 gives 0x000000000000001B.
- R7: In compression mode, a write to 0x64 folds the word {W, 32'h0}.
- R8: In a fold, each byte lane of W whose strobe is 0 counts as zero.
- R9: Every fold copies the new signature into the result registers: bits 31:0 at 0x68 and bits 63:32 at 0x6C. No other event changes the result copies. A fold also sets status bit 0 at 0x28. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R10: Reads of any offset not listed here return zero. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request strobe for one bus access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 4 | Byte strobes for the write lanes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_ready | output | 1 | Access complete; always 1, so no back-pressure |

## Verification
The fold is exercised with several kinds of data. A single low byte on a zero seed has a known answer, 0x1B, which checks the polynomial taps and the bit order. A ten-byte stream from a nonzero seed checks that the running signature chains correctly from one fold to the next. A full word written to the high half checks the placement {W, 0} against the placement {0, W}. A write with only some byte strobes set checks that the unselected lanes become zero. Capture writes with partial strobes show that capture mode merges bytes and does not fold them. The reserved mode values show that they store the data instead of folding it.

// File: rtl/sigcrc_pkg.sv
package sigcrc_pkg;
  localparam int SIG_W = 64;
  localparam int HALF_W = SIG_W / 2;

  typedef enum logic [1:0] {
    MODE_CAPT = 2'd0,
    MODE_RSV1 = 2'd1,
    MODE_RSV2 = 2'd2,
    MODE_FULL = 2'd3
  } mode_e;

  localparam logic [7:0] OFF_CTRL0  = 8'h00;
  localparam logic [7:0] OFF_CTRL2  = 8'h10;
  localparam logic [7:0] OFF_STAT   = 8'h28;
  localparam logic [7:0] OFF_SIG_LO = 8'h60;
  localparam logic [7:0] OFF_SIG_HI = 8'h64;
  localparam logic [7:0] OFF_RES_LO = 8'h68;
  localparam logic [7:0] OFF_RES_HI = 8'h6C;

  // Serial-equivalent fold, data MSB first, unrolled into one clock
  function automatic logic [SIG_W-1:0] crc_fold(input logic [SIG_W-1:0] s,
                                               input logic [SIG_W-1:0] d,
                                               input logic [SIG_W-1:0] poly);
    logic [SIG_W-1:0] acc;
    logic fb;
    acc = s;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      fb  = acc[SIG_W-1] ^ d[i];
      acc = {acc[SIG_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return acc;
  endfunction

  function automatic logic [HALF_W-1:0] lane_mask(input logic [HALF_W/8-1:0] be);
    logic [HALF_W-1:0] m;
    for (int b = 0; b < HALF_W / 8; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/sigcrc_ctrl.sv
module sigcrc_ctrl
  import sigcrc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl0,
  input  logic          wr_ctrl2,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  input  logic          be0,
  input  logic          fold_evt,
  output logic          soft_rst,
  output mode_e         mode,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst <= 1'b0;
      mode     <= MODE_CAPT;
      done     <= 1'b0;
    end else begin
      if (wr_ctrl0 && be0) soft_rst <= wdata[0];
      if (wr_ctrl2 && be0) mode <= mode_e'(wdata[1:0]);
      if (fold_evt) done <= 1'b1;
      else if (wr_stat && be0 && wdata[0]) done <= 1'b0;
    end
  end
endmodule

// File: rtl/sigcrc_sig.sv
module sigcrc_sig
  import sigcrc_pkg::*;
#(
  parameter logic [SIG_W-1:0] POLY = 64'h1B
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                full_mode,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  input  logic [HALF_W/8-1:0] be,
  output logic                fold_evt,
  output logic [SIG_W-1:0]    sig,
  output logic [SIG_W-1:0]    res
);
  logic [HALF_W-1:0] mask, mdata;
  logic [SIG_W-1:0]  fold_word, fold_next;

  always_comb begin
    mask      = lane_mask(be);
    mdata     = wdata & mask;
    fold_word = wr_hi ? {mdata, {HALF_W{1'b0}}} : {{HALF_W{1'b0}}, mdata};
    fold_evt  = (wr_lo || wr_hi) && full_mode && !soft_rst;
    fold_next = crc_fold(sig, fold_word, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig <= '0;
      res <= '0;
    end else if (soft_rst) begin
      sig <= '0;
    end else if (fold_evt) begin
      sig <= fold_next;
      res <= fold_next;
    end else if (wr_lo) begin
      sig[HALF_W-1:0] <= (sig[HALF_W-1:0] & ~mask) | mdata;
    end else if (wr_hi) begin
      sig[SIG_W-1:HALF_W] <= (sig[SIG_W-1:HALF_W] & ~mask) | mdata;
    end
  end
endmodule

// File: rtl/sig_crc_engine.sv
module sig_crc_engine
  import sigcrc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [63:0] POLY = 64'h1B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW/8-1:0] bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ready
);
  logic       wr;
  logic       soft_rst, done, fold_evt;
  mode_e      mode;
  logic [SIG_W-1:0] sig, res;

  assign wr        = bus_sel && bus_we;
  assign bus_ready = 1'b1;

  sigcrc_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl0(wr && bus_addr == AW'(OFF_CTRL0)),
    .wr_ctrl2(wr && bus_addr == AW'(OFF_CTRL2)),
    .wr_stat (wr && bus_addr == AW'(OFF_STAT)),
    .wdata(bus_wdata), .be0(bus_be[0]), .fold_evt(fold_evt),
    .soft_rst(soft_rst), .mode(mode), .done(done)
  );

  sigcrc_sig #(.POLY(POLY)) sig_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .full_mode(mode == MODE_FULL),
    .wr_lo(wr && bus_addr == AW'(OFF_SIG_LO)),
    .wr_hi(wr && bus_addr == AW'(OFF_SIG_HI)),
    .wdata(bus_wdata), .be(bus_be),
    .fold_evt(fold_evt), .sig(sig), .res(res)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFF_CTRL0):  bus_rdata = DW'(soft_rst);
      AW'(OFF_CTRL2):  bus_rdata = DW'(mode);
      AW'(OFF_STAT):   bus_rdata = DW'(done);
      AW'(OFF_SIG_LO): bus_rdata = sig[HALF_W-1:0];
      AW'(OFF_SIG_HI): bus_rdata = sig[SIG_W-1:HALF_W];
      AW'(OFF_RES_LO): bus_rdata = res[HALF_W-1:0];
      AW'(OFF_RES_HI): bus_rdata = res[SIG_W-1:HALF_W];
      default:         bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sigcrc_engine_chk.sv
module sigcrc_engine_chk
  import sigcrc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        soft_rst,
  input mode_e       mode,
  input logic        done,
  input logic [63:0] sig,
  input logic [63:0] res
);
  logic sig_wr, fold_now, known;
  assign sig_wr   = bus_sel && bus_we && (bus_addr == OFF_SIG_LO || bus_addr == OFF_SIG_HI);
  assign fold_now = sig_wr && mode == MODE_FULL && !soft_rst;
  assign known    = bus_addr inside {OFF_CTRL0, OFF_CTRL2, OFF_STAT, OFF_SIG_LO,
                                     OFF_SIG_HI, OFF_RES_LO, OFF_RES_HI};

  // R3
  soft_rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> sig == 64'h0);

  // R5
  capt_lo_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFF_SIG_LO && bus_be == 4'hF && mode != MODE_FULL && !soft_rst)
    |=> (sig[31:0] == $past(bus_wdata)) && (sig[63:32] == $past(sig[63:32])));

  // R9
  fold_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold_now |=> done && (res == sig));

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fold_now |=> $stable(res));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && bus_addr == OFF_CTRL2) |=> $stable(mode));

  // R10
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> bus_rdata == 32'h0);
endmodule

bind sig_crc_engine sigcrc_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .soft_rst(soft_rst), .mode(mode), .done(done),
  .sig(sig), .res(res)
);

// File: tb/sig_crc_engine_tb_top.sv
module sig_crc_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  int n_chk = 0, n_fail = 0;
  logic [63:0] m_sig;

  always #10 clk = ~clk;

  sig_crc_engine dut_i (.*);

  // reference fold built straight from R6: bitwise, data MSB first
  function automatic logic [63:0] ref_fold(input logic [63:0] s, input logic [63:0] d);
    logic [63:0] r = s;
    for (int k = 0; k < 64; k++) begin
      logic top = r[63] ^ d[63-k];
      r = r << 1;
      if (top) r = r ^ 64'h000000000000001B;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_mask(input logic [31:0] w, input logic [3:0] be);
    logic [31:0] o = '0;
    for (int b = 0; b < 4; b++) if (be[b]) o[b*8 +: 8] = w[b*8 +: 8];
    return o;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_be = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic rd64(input logic [7:0] lo, output logic [63:0] v);
    logic [31:0] l, h;
    rd(lo, l); rd(lo + 8'h4, h);
    v = {h, l};
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [63:0] v;
    rd(8'h00, d); check("R1 ctrl0", 64'(d), 0);
    rd(8'h10, d); check("R1 mode", 64'(d), 0);
    rd(8'h28, d); check("R1 status", 64'(d), 0);
    rd64(8'h60, v); check("R1 sig", v, 0);
    rd64(8'h68, v); check("R1 result", v, 0);
    check("R2 ready", 64'(bus_ready), 1);
  endtask

  task automatic t_known_vector();
    logic [63:0] v; logic [31:0] d;
    wr(8'h10, 32'h3, 4'h1);
    wr(8'h60, 32'h01, 4'h1);
    rd64(8'h60, v); check("R6 known 0x1B", v, 64'h1B);
    rd64(8'h68, v); check("R9 result copy", v, 64'h1B);
    rd(8'h28, d); check("R9 status set", 64'(d), 1);
    wr(8'h28, 32'h0, 4'h1);
    rd(8'h28, d); check("R9 write0 keeps", 64'(d), 1);
    wr(8'h28, 32'h1, 4'h1);
    rd(8'h28, d); check("R9 w1c", 64'(d), 0);
  endtask

  task automatic t_seed_and_stream();
    logic [63:0] v;
    logic [7:0] bytes [10] = '{8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h12, 8'h9E, 8'h47, 8'h00, 8'h81, 8'h6D};
    wr(8'h10, 32'h0, 4'h1);
    wr(8'h60, 32'h89ABCDEF, 4'hF);
    wr(8'h64, 32'h01234567, 4'hF);
    rd64(8'h60, v); check("R5 seed load", v, 64'h0123456789ABCDEF);
    rd64(8'h68, v); check("R9 result untouched by capture", v, 64'h1B);
    m_sig = 64'h0123456789ABCDEF;
    wr(8'h10, 32'h3, 4'h1);
    foreach (bytes[i]) begin
      wr(8'h60, {24'h0, bytes[i]}, 4'h1);
      m_sig = ref_fold(m_sig, {56'h0, bytes[i]});
    end
    rd64(8'h60, v); check("R6 byte stream", v, m_sig);
  endtask

  task automatic t_high_word();
    logic [63:0] v;
    wr(8'h64, 32'hDEADBEEF, 4'hF);
    m_sig = ref_fold(m_sig, {32'hDEADBEEF, 32'h0});
    rd64(8'h60, v); check("R7 high fold", v, m_sig);
    wr(8'h60, 32'hDEADBEEF, 4'hF);
    m_sig = ref_fold(m_sig, {32'h0, 32'hDEADBEEF});
    rd64(8'h60, v); check("R6 low full word", v, m_sig);
  endtask

  task automatic t_narrow();
    logic [63:0] v;
    wr(8'h60, 32'hCAFEF00D, 4'b1010);
    m_sig = ref_fold(m_sig, {32'h0, ref_mask(32'hCAFEF00D, 4'b1010)});
    rd64(8'h60, v); check("R8 narrow low", v, m_sig);
    wr(8'h64, 32'h5A5A1234, 4'b0100);
    m_sig = ref_fold(m_sig, {ref_mask(32'h5A5A1234, 4'b0100), 32'h0});
    rd64(8'h60, v); check("R8 narrow high", v, m_sig);
    rd64(8'h68, v); check("R9 result tracks", v, m_sig);
  endtask

  task automatic t_capture_bytes_and_reserved();
    logic [63:0] v;
    wr(8'h10, 32'h0, 4'h1);
    wr(8'h60, 32'h11223344, 4'hF);
    wr(8'h64, 32'h55667788, 4'hF);
    wr(8'h60, 32'hAABBCCDD, 4'b0101);
    rd64(8'h60, v); check("R5 byte merge", v, 64'h5566778811BB33DD);
    wr(8'h10, 32'h1, 4'h1);
    wr(8'h64, 32'h0000EE00, 4'b0010);
    rd64(8'h60, v); check("R4 mode1 captures", v, 64'h5566EE8811BB33DD);
    wr(8'h10, 32'h2, 4'h1);
    wr(8'h60, 32'h99999999, 4'b1000);
    rd64(8'h60, v); check("R4 mode2 captures", v, 64'h5566EE8899BB33DD);
  endtask

  task automatic t_soft_reset();
    logic [63:0] v; logic [31:0] d;
    wr(8'h10, 32'h3, 4'h1);
    wr(8'h00, 32'h1, 4'h1);
    rd(8'h00, d); check("R3 bit reads 1", 64'(d), 1);
    rd64(8'h60, v); check("R3 sig cleared", v, 0);
    wr(8'h60, 32'h12345678, 4'hF);
    rd64(8'h60, v); check("R3 write ignored", v, 0);
    wr(8'h00, 32'h0, 4'h1);
    wr(8'h60, 32'h01, 4'h1);
    rd64(8'h60, v); check("R3 fold after release", v, 64'h1B);
  endtask

  task automatic t_undefined();
    logic [31:0] d; logic [63:0] v;
    wr(8'h44, 32'hFFFFFFFF, 4'hF);
    rd(8'h44, d); check("R10 undefined read", 64'(d), 0);
    rd(8'h6C + 8'h4, d); check("R10 past result", 64'(d), 0);
    rd64(8'h60, v); check("R10 no side effect", v, 64'h1B);
    rd(8'h10, d); check("R10 mode kept", 64'(d), 3);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_known_vector();
    t_seed_and_stream();
    t_high_word();
    t_narrow();
    t_capture_bytes_and_reserved();
    t_soft_reset();
    t_undefined();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule